// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block is the receive half of a clock-synchronous serial port. It collects 8-bit frames from a serial data line. Each bit is taken on a rising edge of a transfer clock. In master mode the block makes that clock itself by dividing the system clock. In slave mode it takes the clock from an input pin and brings it into the system clock domain.

Software sees a small register-style view: a receive enable, an interrupt enable, a byte register, a full flag, an overrun flag and an interrupt line. A read strobe marks a read of the byte register. A clear strobe stands for software writing 0 to the overrun flag.

A frame that completes while the previous byte is still unread is not stored. Instead it raises the overrun flag. From then on the receiver stays frozen until software clears that flag. In master mode the frozen state also stops the generated clock.

Top module: `csrx_top`

## Requirements
- R1: While `rx_en` is 0, transfer clock edges have no effect: `rx_full` does not change. The bit position is reset, so a frame started before a disable is discarded and the next frame after re-enable begins at bit 0.
- R2: Master mode (`cfg_master`=1) drives `sclk_out`, which idles at 1. It toggles every N system cycles, where N is `cfg_div` and a value of 0 counts as 1, giving a 2N-cycle period. It runs only while `rx_en`=1 and `rx_ovr`=0, and data is taken at its rising edges.
- R3: Slave mode (`cfg_master`=0) takes a bit at each rising edge of `sclk_in`. Both `sclk_in` and `sdata_in` pass through two synchronizing flops first. `sclk_out` stays at 1 in this mode.
- R4: The first bit of a frame is bit 0 of `rx_data`, and the eighth is bit 7. At the eighth edge the byte is written to `rx_data` and `rx_full` goes to 1.
- R5: `rx_irq` is 1 exactly when `rx_full` and `irq_en` are both 1.
- R6: A one-cycle `rd_strobe` pulse clears `rx_full` to 0. A read in the same cycle as a frame's eighth edge counts as done before that edge.
- R7: If `rx_full` is still 1 at a frame's eighth edge, `rx_ovr` is set to 1, the new byte is dropped, and `rx_data` keeps the unread byte.
- R8: While `rx_ovr` is 1, no bit is taken and `rx_data` and `rx_full` can only change by a read, whatever clock edges arrive.
- R9: A `ovr_clr` pulse clears `rx_ovr` and restarts the frame at bit 0, after which reception continues normally.
- R10: After reset, `rx_data`=0, `rx_full`=0, `rx_ovr`=0, `rx_irq`=0 and `sclk_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the transfer clock, 0: take it from `sclk_in` |
| cfg_div | input | DIVW | Half-period of the generated clock in system cycles (0 acts as 1) |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle pulse: the byte register is being read |
| ovr_clr | input | 1 | One-cycle pulse: clear the overrun flag |
| sclk_in | input | 1 | External transfer clock (slave mode) |
| sdata_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated transfer clock (master mode), idles high |
| rx_data | output | FRAME_W | Received byte register |
| rx_full | output | 1 | Byte register holds unread data |
| rx_ovr | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions assume that `cfg_master` and `cfg_div` change only while `rx_en` is 0. They also assume that `rd_strobe` and `ovr_clr` are single-cycle pulses, and that in slave mode each level of `sclk_in` lasts at least two system cycles so the synchronizer sees every edge. The stimulus follows these rules. Configuration is changed only with reception disabled. Each slave bit is held for four cycles low and four cycles high. In master mode, new data is driven only after a falling edge of `sclk_out`, so it is settled well before the next rising edge.

// File: rtl/csrx_pkg.sv
package csrx_pkg;

  // Half-period of the generated transfer clock; a zero setting behaves as one.
  function automatic int unsigned half_cycles(input int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

  // Index of the final bit in a frame of the given length.
  function automatic int unsigned last_bit(input int unsigned frame_w);
    return frame_w - 1;
  endfunction

endpackage

// File: rtl/csrx_mclk.sv
module csrx_mclk #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            sclk,
  output logic            rise_evt
);
  import csrx_pkg::*;

  logic [DIVW-1:0] cnt;
  logic            sclk_q;
  logic            at_end;

  assign at_end   = (cnt == DIVW'(half_cycles(32'(div)) - 1));
  assign rise_evt = run && at_end && !sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (!run) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (at_end) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sclk);

  // R2
  rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> $rose(sclk));

endmodule

// File: rtl/csrx_sync.sv
module csrx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic sdat_pin,
  output logic rise_evt,
  output logic sdat_s
);
  logic [2:0] ck_q;
  logic [1:0] dt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= 3'b111;
      dt_q <= 2'b00;
    end else begin
      ck_q <= {ck_q[1:0], sclk_pin};
      dt_q <= {dt_q[0], sdat_pin};
    end
  end

  assign rise_evt = ck_q[1] && !ck_q[2];
  assign sdat_s   = dt_q[1];

  // R3
  edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

endmodule

// File: rtl/csrx_frame.sv
module csrx_frame #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               smp,
  input  logic               bit_in,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word
);
  import csrx_pkg::*;

  localparam int CW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  logic [CW-1:0]      pos;
  logic [FRAME_W-1:0] shreg;
  logic               at_last;

  assign at_last    = (pos == CW'(last_bit(FRAME_W)));
  assign frame_done = smp && at_last;
  // first bit travels down to bit 0 by the end of the frame
  assign frame_word = {bit_in, shreg[FRAME_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      shreg <= '0;
    end else if (clr) begin
      pos   <= '0;
      shreg <= '0;
    end else if (smp) begin
      shreg <= frame_word;
      pos   <= at_last ? '0 : pos + CW'(1);
    end
  end

  // R1
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pos == '0));

endmodule

// File: rtl/csrx_flags.sv
module csrx_flags #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               rd,
  input  logic               ovr_clr,
  output logic [FRAME_W-1:0] data,
  output logic               full,
  output logic               ovr,
  output logic               ovr_evt
);
  logic full_eff;
  logic store;

  assign full_eff = full && !rd;
  assign store    = frame_done && !full_eff;
  assign ovr_evt  = frame_done && full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (store) data <= frame_word;
      if (store)   full <= 1'b1;
      else if (rd) full <= 1'b0;
      if (ovr_evt)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  // R7
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(full));

  // R7
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(data));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !frame_done) |=> !full);

endmodule

// File: rtl/csrx_top.sv
module csrx_top #(
  parameter int DIVW    = 4,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_master,
  input  logic [DIVW-1:0]    cfg_div,
  input  logic               rx_en,
  input  logic               irq_en,
  input  logic               rd_strobe,
  input  logic               ovr_clr,
  input  logic               sclk_in,
  input  logic               sdata_in,
  output logic               sclk_out,
  output logic [FRAME_W-1:0] rx_data,
  output logic               rx_full,
  output logic               rx_ovr,
  output logic               rx_irq
);
  logic active, m_run, m_rise, s_rise, s_dat;
  logic smp, bit_sel, frame_done, ovr_evt, shift_clr;
  logic [FRAME_W-1:0] frame_word;

  assign active    = rx_en && !rx_ovr;
  assign m_run     = active && cfg_master;
  assign smp       = active && (cfg_master ? m_rise : s_rise);
  assign bit_sel   = cfg_master ? sdata_in : s_dat;
  assign shift_clr = !rx_en || ovr_clr;
  assign rx_irq    = rx_full && irq_en;

  csrx_mclk #(.DIVW(DIVW)) u_mclk (
    .clk(clk), .rst_n(rst_n), .run(m_run), .div(cfg_div),
    .sclk(sclk_out), .rise_evt(m_rise)
  );

  csrx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_in), .sdat_pin(sdata_in),
    .rise_evt(s_rise), .sdat_s(s_dat)
  );

  csrx_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(shift_clr), .smp(smp), .bit_in(bit_sel),
    .frame_done(frame_done), .frame_word(frame_word)
  );

  csrx_flags #(.FRAME_W(FRAME_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_word(frame_word),
    .rd(rd_strobe), .ovr_clr(ovr_clr), .data(rx_data), .full(rx_full),
    .ovr(rx_ovr), .ovr_evt(ovr_evt)
  );

  // R8
  frozen_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !ovr_clr) |=> !frame_done);

  // R8
  frozen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !ovr_clr) |=> $stable(rx_data));

  // R4
  full_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(frame_done));

  // R1
  disabled_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !$past(rx_en)) |-> !$rose(rx_full));

endmodule

// File: tb/sim_csrx_top.sv
`timescale 1ns/1ps
module sim_csrx_top;
  localparam int DIVW = 4;
  localparam int FW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b0;
  logic [DIVW-1:0] cfg_div = '0;
  logic rx_en = 1'b0, irq_en = 1'b0, rd_strobe = 1'b0, ovr_clr = 1'b0;
  logic sclk_in = 1'b1, sdata_in = 1'b0;
  logic sclk_out, rx_full, rx_ovr, rx_irq;
  logic [FW-1:0] rx_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  csrx_top #(.DIVW(DIVW), .FRAME_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .rx_en(rx_en), .irq_en(irq_en), .rd_strobe(rd_strobe), .ovr_clr(ovr_clr),
    .sclk_in(sclk_in), .sdata_in(sdata_in), .sclk_out(sclk_out),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic s_bits(input logic [FW-1:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk_in = 1'b0; sdata_in = b[i];
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic m_byte(input logic [FW-1:0] b);
    for (int i = 0; i < FW; i++) begin
      @(negedge sclk_out);
      @(negedge clk);
      sdata_in = b[i];
    end
    @(posedge sclk_out);
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] v;
    int hits;
    longint t0, t1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 data", rx_data, 0);
    check("R10 full", rx_full, 0);
    check("R10 ovr", rx_ovr, 0);
    check("R10 irq", rx_irq, 0);
    check("R10 sclk_out", sclk_out, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 disabled: edges ignored
    s_bits(8'hFF, FW);
    check("R1 full while disabled", rx_full, 0);

    // R3 R4 slave sweep over every byte value, R6 read clears
    rx_en = 1'b1;
    for (int k = 0; k < 256; k++) begin
      v = FW'(k);
      s_bits(v, FW);
      check("R4 slave data", rx_data, int'(v));
      check("R4 full set", rx_full, 1);
      check("R3 sclk_out idle in slave", sclk_out, 1);
      pulse_rd();
      check("R6 read clears full", rx_full, 0);
    end

    // R5 irq follows full and enable
    s_bits(8'hA5, FW);
    check("R5 irq off", rx_irq, 0);
    irq_en = 1'b1; @(negedge clk);
    check("R5 irq on", rx_irq, 1);
    // R7 overrun
    s_bits(8'h3C, FW);
    check("R7 ovr set", rx_ovr, 1);
    check("R7 data kept", rx_data, 8'hA5);
    check("R7 full kept", rx_full, 1);
    // R8 frozen
    s_bits(8'hFF, FW);
    check("R8 data frozen", rx_data, 8'hA5);
    pulse_rd();
    check("R5 irq drops with full", rx_irq, 0);
    s_bits(8'h11, FW);
    check("R8 no reception", rx_full, 0);
    check("R8 ovr held", rx_ovr, 1);
    // R9 clear and resume
    pulse_clr();
    check("R9 ovr cleared", rx_ovr, 0);
    s_bits(8'h22, FW);
    check("R9 resumed data", rx_data, 8'h22);
    check("R9 resumed full", rx_full, 1);
    pulse_rd();

    // R1 disable mid-frame discards the partial bits
    s_bits(8'h07, 3);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    s_bits(8'h96, FW);
    check("R1 restart at bit0", rx_data, 8'h96);
    pulse_rd();
    rx_en = 1'b0; irq_en = 1'b0;

    // R2 master mode across dividers (0 behaves as 1)
    cfg_master = 1'b1;
    for (int n = 0; n < 4; n++) begin
      int hc;
      hc = (n == 0) ? 1 : n;
      v = FW'(8'hC3 ^ FW'(n * 37));
      @(negedge clk); cfg_div = DIVW'(n); rx_en = 1'b1;
      m_byte(v);
      check("R2 master data", rx_data, int'(v));
      check("R4 master full", rx_full, 1);
      @(posedge sclk_out); t0 = $time;
      @(posedge sclk_out); t1 = $time;
      check("R2 period", int'(t1 - t0), 2 * hc * 10);
      @(negedge clk); rx_en = 1'b0;
      @(negedge clk);
      check("R2 idle high", sclk_out, 1);
      pulse_rd();
    end

    // R7 R8 master overrun stops the clock, R9 restart
    @(negedge clk); cfg_div = DIVW'(2); rx_en = 1'b1;
    m_byte(8'h5A);
    m_byte(8'hE1);
    check("R7 master ovr", rx_ovr, 1);
    check("R7 master data kept", rx_data, 8'h5A);
    hits = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (sclk_out == 1'b0) hits++;
    end
    check("R8 clock halted", hits, 0);
    pulse_rd();
    pulse_clr();
    m_byte(8'h3D);
    check("R9 master resumed", rx_data, 8'h3D);
    check("R9 master ovr clear", rx_ovr, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule